// File: doc/BRIEF.md
# SDRAM Refresh Backlog Scheduler

This block decides when a memory controller spends bus time on SDRAM refresh. A reloadable down-counter produces a refresh request every programmed interval, and a saturating two-bit backlog counter records how many of those requests are still owed. While the backlog is partly filled, the block asks the access arbiter for the bus only when no access is in progress. Each granted slot produces a close-all-banks strobe followed by one auto-refresh strobe.

When the backlog reaches its ceiling of three, the block becomes urgent. It requests the bus even if an access is running. Once granted, it closes all banks once and then issues refreshes back to back until the backlog is empty. Refreshes inside such a burst keep a programmable minimum row-cycle spacing. On every close and every refresh cycle the block tells the page tracker that its open-row record is stale. The backlog starts full after reset, so a complete drain always happens before the first normal access.

Top module: `refresh_backlog_sched`

## Requirements
- R1: After reset the backlog output reads 3 (binary 11), and no strobe, bus request or urgent flag is active while `refresh_en` is low.
- R2: While `refresh_en` is low and no sequence is under way, `bus_req`, `cmd_precharge_all` and `cmd_refresh` stay low, and the interval timer reloads from `period_cfg`.
- R3: With `refresh_en` high, the timer produces one tick every `period_cfg`+1 cycles, counted from the cycle it is enabled with a freshly loaded value. Each tick raises the backlog by one in the following cycle.
- R4: Every granted slot begins with a single-cycle `cmd_precharge_all`, and `cmd_refresh` follows in the very next cycle.
- R5: Each `cmd_refresh` lowers the backlog by one. The backlog saturates at 3, so a tick that arrives while it is 3 is lost.
- R6: With the backlog at 3 and `refresh_en` high, `bus_req` and `urgent` are raised regardless of `access_busy`. After the grant, one close-all strobe is followed by refreshes until the backlog is 0.
- R7: With the backlog at 1 or 2, `bus_req` is raised only while `access_busy` is low, and a grant then yields exactly one close-all plus one refresh.
- R8: `page_invalidate` is high in exactly the cycles in which `cmd_precharge_all` or `cmd_refresh` is high.
- R9: Two `cmd_refresh` strobes inside one urgent burst are exactly max(`trc_cfg`,1)+1 cycles apart, and no two refresh strobes are ever closer than that.
- R10: A close-all strobe appears only in the cycle after a cycle with `bus_req` and `bus_grant` both high. `bus_req` remains high until the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_en | input | 1 | Refresh generation enable |
| period_cfg | input | PERIOD_W | Interval reload value, in cycles minus one |
| trc_cfg | input | GAP_W | Minimum row-cycle gap between refreshes |
| access_busy | input | 1 | An ordinary access is in progress |
| bus_grant | input | 1 | Arbiter grants the command slot |
| bus_req | output | 1 | Request for the command slot |
| cmd_precharge_all | output | 1 | Close-all-banks command strobe |
| cmd_refresh | output | 1 | Auto-refresh command strobe |
| page_invalidate | output | 1 | Open-row record is no longer valid |
| urgent | output | 1 | Backlog full or urgent burst under way |
| backlog | output | 2 | Outstanding refresh count |

## Verification
The bench targets three corner cases.

- **Reset-time drain.** A design that started the backlog at zero would issue nothing. One that closed the banks before every refresh would show three close-all strobes instead of one.
- **Tick arriving at a full backlog.** A counter that wrapped to zero would never start the urgent drain. One that kept counting would drain four times instead of three.
- **Busy gating.** A request raised during an access at backlog 1 or 2 is wrong. So is a request withheld at backlog 3, since the controller could then starve refresh.

Burst spacing is compared against `trc_cfg` cycle by cycle, so an off-by-one in the gap counter shows up as a strobe stamped one cycle early or late.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_PRE,
    RS_REF,
    RS_GAP
  } rfs_state_e;

  localparam logic [1:0] BACKLOG_FULL = 2'b11;

  // Next backlog value: a tick adds one unless full, a finished refresh removes one.
  function automatic logic [1:0] backlog_next(input logic [1:0] cur,
                                              input logic tick,
                                              input logic done);
    logic [1:0] v;
    v = cur;
    if (tick && (cur != BACKLOG_FULL)) v = v + 2'd1;
    if (done && (v != 2'd0)) v = v - 2'd1;
    return v;
  endfunction

  // Gap counter has served its time when it reaches one or less.
  function automatic logic gap_served(input logic [7:0] gcnt);
    return (gcnt <= 8'd1);
  endfunction

endpackage

// File: rtl/rfs_period_timer.sv
module rfs_period_timer #(
  parameter int PERIOD_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] tmr_q;

  assign tick = en && (tmr_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (!en || tick) begin
      tmr_q <= period;
    end else begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (tmr_q == $past(period)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);
endmodule

// File: rtl/rfs_backlog_ctr.sv
module rfs_backlog_ctr
  import rfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       done,
  output logic [1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= BACKLOG_FULL;
    else        cnt <= backlog_next(cnt, tick, done);
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == BACKLOG_FULL && tick && !done) |=> (cnt == BACKLOG_FULL));

  assert_drain_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tick && cnt != 2'd0) |=> (cnt == $past(cnt) - 2'd1));
endmodule

// File: rtl/rfs_cmd_fsm.sv
module rfs_cmd_fsm
  import rfs_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       cnt,
  input  logic             access_busy,
  input  logic             bus_grant,
  input  logic [GAP_W-1:0] trc,
  output logic             bus_req,
  output logic             cmd_pre,
  output logic             cmd_ref,
  output logic             page_inv,
  output logic             drain
);
  rfs_state_e       state_q;
  logic [GAP_W-1:0] gcnt_q;
  logic             drain_q;
  logic             want;
  logic             gap_ok;

  // A partial backlog waits for an idle bus; a full one does not.
  assign want    = en && (cnt != 2'd0) && ((cnt == BACKLOG_FULL) || !access_busy);
  assign bus_req = (state_q != RS_IDLE) || want;
  assign cmd_pre = (state_q == RS_PRE);
  assign cmd_ref = (state_q == RS_REF);
  assign page_inv = (state_q == RS_PRE) || (state_q == RS_REF);
  assign drain   = drain_q;
  assign gap_ok  = gap_served(8'(gcnt_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      gcnt_q  <= '0;
      drain_q <= 1'b0;
    end else begin
      case (state_q)
        RS_IDLE: if (want && bus_grant) begin
          state_q <= RS_PRE;
          drain_q <= (cnt == BACKLOG_FULL);
        end
        RS_PRE: state_q <= RS_REF;
        RS_REF: begin
          state_q <= RS_GAP;
          gcnt_q  <= trc;
        end
        RS_GAP: begin
          if (gcnt_q != '0) gcnt_q <= gcnt_q - 1'b1;
          if (gap_ok) begin
            if (drain_q && en && (cnt != 2'd0)) begin
              state_q <= RS_REF;
            end else begin
              state_q <= RS_IDLE;
              drain_q <= 1'b0;
            end
          end
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assert_pre_then_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |=> cmd_ref);

  assert_granted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |-> $past(bus_req && bus_grant));

  assert_urgent_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_IDLE && en && cnt == BACKLOG_FULL) |-> bus_req);

  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_IDLE && access_busy && cnt != BACKLOG_FULL) |-> !bus_req);

  assert_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_IDLE && !en) |-> !bus_req);
endmodule

// File: rtl/refresh_backlog_sched.sv
module refresh_backlog_sched #(
  parameter int PERIOD_W = 12,
  parameter int GAP_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                refresh_en,
  input  logic [PERIOD_W-1:0] period_cfg,
  input  logic [GAP_W-1:0]    trc_cfg,
  input  logic                access_busy,
  input  logic                bus_grant,
  output logic                bus_req,
  output logic                cmd_precharge_all,
  output logic                cmd_refresh,
  output logic                page_invalidate,
  output logic                urgent,
  output logic [1:0]          backlog
);
  localparam int SINCE_W = GAP_W + 1;

  logic       tick;
  logic [1:0] cnt;
  logic       drain;

  rfs_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (refresh_en),
    .period (period_cfg),
    .tick   (tick)
  );

  rfs_backlog_ctr u_backlog (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .done  (cmd_refresh),
    .cnt   (cnt)
  );

  rfs_cmd_fsm #(.GAP_W(GAP_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (refresh_en),
    .cnt         (cnt),
    .access_busy (access_busy),
    .bus_grant   (bus_grant),
    .trc         (trc_cfg),
    .bus_req     (bus_req),
    .cmd_pre     (cmd_precharge_all),
    .cmd_ref     (cmd_refresh),
    .page_inv    (page_invalidate),
    .drain       (drain)
  );

  assign backlog = cnt;
  assign urgent  = drain || (refresh_en && cnt == rfs_pkg::BACKLOG_FULL);

  // Cycles since the last refresh strobe, for the spacing check.
  logic [SINCE_W-1:0] since_q;
  logic               seen_ref_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q    <= '0;
      seen_ref_q <= 1'b0;
    end else if (cmd_refresh) begin
      since_q    <= '0;
      seen_ref_q <= 1'b1;
    end else if (since_q != {SINCE_W{1'b1}}) begin
      since_q <= since_q + 1'b1;
    end
  end

  assert_min_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_refresh && seen_ref_q) |-> (since_q >= SINCE_W'(trc_cfg)));

  assert_page_stale_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_precharge_all || cmd_refresh) |-> page_invalidate);

  assert_one_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_precharge_all && cmd_refresh));
endmodule

// File: tb/test_refresh_backlog_sched.sv
module test_refresh_backlog_sched;
  localparam int PW = 12;
  localparam int GW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          refresh_en = 1'b0;
  logic [PW-1:0] period_cfg = 12'd1000;
  logic [GW-1:0] trc_cfg = 4'd3;
  logic          access_busy = 1'b0;
  logic          grant_auto = 1'b1;
  logic          bus_grant;
  logic          bus_req, cmd_precharge_all, cmd_refresh, page_invalidate, urgent;
  logic [1:0]    backlog;

  assign bus_grant = grant_auto && bus_req;

  refresh_backlog_sched #(.PERIOD_W(PW), .GAP_W(GW)) i_refresh_backlog_sched (
    .clk(clk), .rst_n(rst_n), .refresh_en(refresh_en), .period_cfg(period_cfg),
    .trc_cfg(trc_cfg), .access_busy(access_busy), .bus_grant(bus_grant),
    .bus_req(bus_req), .cmd_precharge_all(cmd_precharge_all), .cmd_refresh(cmd_refresh),
    .page_invalidate(page_invalidate), .urgent(urgent), .backlog(backlog)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int exp_kind[$];
  int exp_cyc[$];
  string exp_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver side: push one expected strobe (1 = close-all, 2 = refresh).
  task automatic expect_cmd(input int kind, input int at, input string tag);
    exp_kind.push_back(kind);
    exp_cyc.push_back(at);
    exp_tag.push_back(tag);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Monitor: compare every strobe with the front of the queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_precharge_all || cmd_refresh) begin
        int kind;
        kind = cmd_precharge_all ? 1 : 2;
        check(page_invalidate === 1'b1, "R8 page_invalidate on strobe", page_invalidate, 1);
        if (exp_kind.size() == 0) begin
          check(1'b0, "R2 unexpected strobe", kind, 0);
        end else begin
          int ek, ec;
          string et;
          ek = exp_kind.pop_front();
          ec = exp_cyc.pop_front();
          et = exp_tag.pop_front();
          check(kind == ek, {et, " strobe kind"}, kind, ek);
          check(cyc == ec, {et, " strobe cycle"}, cyc, ec);
        end
      end else if (page_invalidate) begin
        check(1'b0, "R8 page_invalidate without strobe", 1, 0);
      end
    end
  end

  initial begin
    int c0, c1, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and R2 gating while disabled
    check(backlog == 2'd3, "R1 backlog after reset", backlog, 3);
    check(!urgent, "R1 urgent while disabled", urgent, 0);
    repeat (10) @(negedge clk);
    check(!bus_req, "R2 no request while disabled", bus_req, 0);
    check(backlog == 2'd3, "R2 backlog held while disabled", backlog, 3);

    // R6/R9: reset-time urgent drain, one close-all then three refreshes
    c0 = cyc;
    expect_cmd(1, c0 + 1, "R6 drain close-all");
    expect_cmd(2, c0 + 2, "R4 refresh after close-all");
    expect_cmd(2, c0 + 6, "R9 burst spacing trc=3");
    expect_cmd(2, c0 + 10, "R9 burst spacing trc=3");
    refresh_en = 1'b1;
    @(negedge clk);
    check(urgent == 1'b1, "R6 urgent during drain", urgent, 1);
    check(bus_req == 1'b1, "R10 request held in sequence", bus_req, 1);
    wait_cyc(c0 + 14);
    check(backlog == 2'd0, "R5 backlog drained", backlog, 0);
    check(!urgent, "R6 urgent cleared", urgent, 0);

    // R3/R7: periodic single refreshes, period 20, trc 2
    period_cfg = 12'd20;
    trc_cfg = 4'd2;
    refresh_en = 1'b0;
    @(negedge clk);
    c1 = cyc;
    refresh_en = 1'b1;
    expect_cmd(1, c1 + 22, "R7 normal close-all");
    expect_cmd(2, c1 + 23, "R4 normal refresh");
    expect_cmd(1, c1 + 43, "R3 second tick close-all");
    expect_cmd(2, c1 + 44, "R4 normal refresh");
    wait_cyc(c1 + 20);
    check(backlog == 2'd0, "R3 no tick before period", backlog, 0);
    wait_cyc(c1 + 21);
    check(backlog == 2'd1, "R3 tick raises backlog", backlog, 1);

    // R5/R6/R7: busy and grant withheld across four ticks, then release
    wait_cyc(c1 + 50);
    access_busy = 1'b1;
    grant_auto = 1'b0;
    wait_cyc(c1 + 63);
    check(backlog == 2'd1, "R3 backlog after tick", backlog, 1);
    check(!bus_req, "R7 no request while busy", bus_req, 0);
    wait_cyc(c1 + 84);
    check(!bus_req, "R7 no request while busy at 2", bus_req, 0);
    wait_cyc(c1 + 105);
    check(backlog == 2'd3, "R5 backlog full", backlog, 3);
    check(bus_req == 1'b1, "R6 urgent request despite busy", bus_req, 1);
    check(urgent == 1'b1, "R6 urgent flag", urgent, 1);
    wait_cyc(c1 + 126);
    check(backlog == 2'd3, "R5 saturation on extra tick", backlog, 3);
    t = c1 + 126;
    expect_cmd(1, t + 1, "R6 drain close-all");
    expect_cmd(2, t + 2, "R5 drain refresh 1");
    expect_cmd(2, t + 5, "R9 burst spacing trc=2");
    expect_cmd(2, t + 8, "R5 drain refresh 3 (saturated)");
    grant_auto = 1'b1;
    wait_cyc(t + 12);
    check(backlog == 2'd0, "R5 drain ends at zero", backlog, 0);

    // R7: partial backlog waits for busy to drop
    wait_cyc(c1 + 150);
    check(backlog == 2'd1, "R3 tick while busy", backlog, 1);
    check(!bus_req, "R7 waits for idle bus", bus_req, 0);
    expect_cmd(1, c1 + 151, "R7 close-all after busy drops");
    expect_cmd(2, c1 + 152, "R4 refresh after busy drops");
    access_busy = 1'b0;
    wait_cyc(c1 + 156);

    // R2: disabled for a long stretch, nothing happens
    refresh_en = 1'b0;
    wait_cyc(c1 + 260);
    check(!bus_req, "R2 no request while disabled", bus_req, 0);
    check(backlog == 2'd0, "R2 backlog unchanged while disabled", backlog, 0);
    check(exp_kind.size() == 0, "R10 all expected strobes seen", exp_kind.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule